// File: doc/BRIEF.md
# Line Sensor Readout Sequencer

This block is the timing core of a linear photodiode array with a charge amplifier per channel. It watches the sensor's slow line clock and its line-reset pulse, and from them it produces four things. The first is the charge integration window. The second is a per-channel video-valid flag that carries the channel index. The third is a sample strobe placed inside each channel slot. The fourth is an active-low end-of-scan marker. The analog path is not modelled. Video appears as a channel index with a valid flag and an output-enable that stands in for the tri-state driver.

Both line inputs are sampled by a faster system clock. The block acts on both edges of the line clock, so every position that falls on a half clock is exact. For sensors chained in series, a slave select makes the scan wait for an external start input. That input is normally tied to the end-of-scan output of the sensor before it. The channel count is a parameter.

Top module: `lsr_sequencer`

## Requirements
- R1: In master mode (`slave_sel`=0), a readout starts on the first `line_clk` falling edge after `line_rst` has gone low. That falling edge is clock 1, and every later falling edge adds one to the clock count.
- R2: Channel c (0-based) is reported with `vid_valid`=1 and `vid_chan`=c from the `line_clk` rising edge at clock 18.5+4c until the falling edge at clock 20+4c. Outside these windows `vid_valid` is 0. This gives one channel per four line clocks.
- R3: `trig` is high from the rising edge at clock 19.5+4c until the falling edge at clock 20+4c, for each channel c. At all other times it is low.
- R4: After the last channel (N = `N_CH`), `eos_n` is low from clock 18.5+4N for exactly four line clocks. The readout then ends and the block returns to idle.
- R5: `vid_oe` is 1 from clock 1 until `eos_n` falls. It is 0 while `eos_n` is low and while the block is idle.
- R6: `integ_win` takes the level that `line_rst` had eight `line_clk` rising edges earlier, counting the rising edge at which `line_rst` changed. The window therefore opens 8 clocks after the rise of `line_rst` and closes 8 clocks after its fall.
- R7: A rising edge of `line_rst` during a readout produces a one-system-cycle pulse on `proto_err`. The readout in progress continues, and every output keeps the timing of R2 to R5.
- R8: A falling edge of `line_rst` during a readout does not queue a new readout. Once the current scan ends, the block stays idle until the next fall of `line_rst` that arrives while it is idle.
- R9: In slave mode (`slave_sel`=1), a readout that has been armed by a fall of `line_rst` starts on the first `line_clk` falling edge at which `ext_start_n` is low. That edge is clock 1. While `ext_start_n` stays high, no readout starts.
- R10: While `rst` is high and just after it is released, `vid_valid`, `trig`, `vid_oe`, `integ_win` and `proto_err` are 0 and `eos_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the line clock |
| rst | input | 1 | Synchronous active-high reset |
| line_clk | input | 1 | Sensor line clock |
| line_rst | input | 1 | Sensor line reset; its high time sets the integration window |
| ext_start_n | input | 1 | External start, active low, used in slave mode |
| slave_sel | input | 1 | 0: master (self-started), 1: slave (waits for `ext_start_n`) |
| integ_win | output | 1 | Charge integration window |
| vid_valid | output | 1 | Video of channel `vid_chan` is valid |
| vid_chan | output | CHW | Index of the channel being read out |
| vid_oe | output | 1 | Video output driver enable (0 = high impedance) |
| trig | output | 1 | Recommended sample strobe |
| eos_n | output | 1 | End of scan, active low |
| proto_err | output | 1 | One-cycle pulse: line reset rose during a readout |

## Verification
The bench builds the block with `N_CH`=4, a two-stage synchronizer and the default delay of eight clocks. At this size a full scan lasts only about 38 line clocks. That makes it practical to compare every output after every single line-clock edge, through three complete readouts and the idle stretches between them. The bench computes each expected value from the half-clock position of that edge. With four channels, the first slot, the last slot and the end-of-scan slot all lie close together and are all covered. Mid-scan line-reset edges, an integration delay longer than the gaps between edges, and a slave start that is held off for many clocks are all reached in a run of a few thousand system cycles.

// File: rtl/lsr_pkg.sv
package lsr_pkg;

    // Positions are counted in half line clocks: the falling edge of
    // clock k is position 2k, the rising edge after it is 2k+1.
    localparam int HC_START    = 2;   // clock 1
    localparam int HC_CH1      = 37;  // clock 18.5: first channel opens
    localparam int HC_SLOT_LG  = 3;   // 8 half clocks = 4 clocks per slot
    localparam int HC_SLOT     = 1 << HC_SLOT_LG;
    localparam int HC_VAL_LEN  = 3;   // valid for 1.5 clocks in each slot
    localparam int HC_TRIG_PH  = 2;   // strobe phase inside the slot

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ARMED = 2'd1,
        SQ_RUN   = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic valid;
        logic trig;
        logic eos;
        logic oe;
    } slot_flags_t;

    // Last half-clock position of a scan for n channels.
    function automatic int hc_last(input int n_ch);
        return HC_CH1 + HC_SLOT * (n_ch + 1) - 1;
    endfunction

    // Flags for one phase of a channel slot.
    function automatic slot_flags_t chan_phase_flags(input logic [HC_SLOT_LG-1:0] ph);
        slot_flags_t f;
        f.valid = (int'(ph) < HC_VAL_LEN);
        f.trig  = (int'(ph) == HC_TRIG_PH);
        f.eos   = 1'b0;
        f.oe    = 1'b1;
        return f;
    endfunction

endpackage

// File: rtl/lsr_sync_edge.sv
module lsr_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= 1'b0;
                else     chain[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= 1'b0;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= chain[STAGES-1];
    end

    assign lvl  = chain[STAGES-1];
    assign rise = chain[STAGES-1] & ~prev;
    assign fall = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/lsr_integ_delay.sv
module lsr_integ_delay #(
    parameter int DLY = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic lvl,
    output logic win
);
    // Tap 0 captures the level on the edge where it changed, so
    // DLY+1 taps put the change DLY edges later at the output.
    logic [DLY:0] taps;

    always_ff @(posedge clk) begin
        if (rst)       taps <= '0;
        else if (step) taps <= {taps[DLY-1:0], lvl};
    end

    assign win = taps[DLY];
endmodule

// File: rtl/lsr_scan_ctrl.sv
module lsr_scan_ctrl
    import lsr_pkg::*;
#(
    parameter int N_CH = 64,
    parameter int HCW  = 10
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clk_rise,
    input  logic           clk_fall,
    input  logic           lrst_rise,
    input  logic           lrst_fall,
    input  logic           ext_lvl,
    input  logic           slave_sel,
    output logic           running,
    output logic [HCW-1:0] hc,
    output logic           proto_err
);
    localparam logic [HCW-1:0] HC_FIRST = HCW'(HC_START);
    localparam logic [HCW-1:0] HC_END   = HCW'(hc_last(N_CH));

    seq_state_t st;
    logic       start_ok;

    assign start_ok = clk_fall && (!slave_sel || !ext_lvl);
    assign running  = (st == SQ_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= SQ_IDLE;
            hc        <= '0;
            proto_err <= 1'b0;
        end else begin
            proto_err <= 1'b0;
            unique case (st)
                SQ_IDLE: begin
                    if (lrst_fall) st <= SQ_ARMED;
                end
                SQ_ARMED: begin
                    if (lrst_rise) begin
                        st <= SQ_IDLE;
                    end else if (start_ok) begin
                        st <= SQ_RUN;
                        hc <= HC_FIRST;
                    end
                end
                SQ_RUN: begin
                    if (lrst_rise) proto_err <= 1'b1;
                    if (clk_rise || clk_fall) begin
                        if (hc == HC_END) begin
                            st <= SQ_IDLE;
                            hc <= '0;
                        end else begin
                            hc <= hc + 1'b1;
                        end
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lsr_slot_decode.sv
module lsr_slot_decode
    import lsr_pkg::*;
#(
    parameter int N_CH = 64,
    parameter int HCW  = 10,
    parameter int CHW  = 6
) (
    input  logic           running,
    input  logic [HCW-1:0] hc,
    output slot_flags_t    flags,
    output logic [CHW-1:0] chan
);
    logic [HCW-1:0]        rel;
    logic [HCW-1:0]        slot;
    logic [HC_SLOT_LG-1:0] ph;

    always_comb begin
        rel   = hc - HCW'(HC_CH1);
        slot  = rel >> HC_SLOT_LG;
        ph    = rel[HC_SLOT_LG-1:0];
        flags = '0;
        chan  = slot[CHW-1:0];
        if (running) begin
            if (hc < HCW'(HC_CH1)) begin
                flags.oe = 1'b1;
            end else if (slot < HCW'(N_CH)) begin
                flags = chan_phase_flags(ph);
            end else begin
                flags.eos = 1'b1;
            end
        end
    end
endmodule

// File: rtl/lsr_sequencer.sv
module lsr_sequencer
    import lsr_pkg::*;
#(
    parameter int N_CH        = 64,
    parameter int SYNC_STAGES = 2,
    parameter int INTEG_DLY   = 8,
    localparam int CHW        = (N_CH > 1) ? $clog2(N_CH) : 1,
    localparam int HCW        = $clog2(HC_CH1 + HC_SLOT * (N_CH + 1) + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           line_clk,
    input  logic           line_rst,
    input  logic           ext_start_n,
    input  logic           slave_sel,
    output logic           integ_win,
    output logic           vid_valid,
    output logic [CHW-1:0] vid_chan,
    output logic           vid_oe,
    output logic           trig,
    output logic           eos_n,
    output logic           proto_err
);
    logic           lc_lvl, lc_rise, lc_fall;
    logic           lr_lvl, lr_rise, lr_fall;
    logic           ex_lvl, ex_rise, ex_fall;
    logic           running;
    logic [HCW-1:0] hc;
    slot_flags_t    flags;

    lsr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_clk (
        .clk(clk), .rst(rst), .d(line_clk),
        .lvl(lc_lvl), .rise(lc_rise), .fall(lc_fall)
    );

    lsr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_rst (
        .clk(clk), .rst(rst), .d(line_rst),
        .lvl(lr_lvl), .rise(lr_rise), .fall(lr_fall)
    );

    lsr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_ext (
        .clk(clk), .rst(rst), .d(ext_start_n),
        .lvl(ex_lvl), .rise(ex_rise), .fall(ex_fall)
    );

    lsr_integ_delay #(.DLY(INTEG_DLY)) u_integ (
        .clk(clk), .rst(rst), .step(lc_rise), .lvl(lr_lvl), .win(integ_win)
    );

    lsr_scan_ctrl #(.N_CH(N_CH), .HCW(HCW)) u_ctrl (
        .clk(clk), .rst(rst),
        .clk_rise(lc_rise), .clk_fall(lc_fall),
        .lrst_rise(lr_rise), .lrst_fall(lr_fall),
        .ext_lvl(ex_lvl), .slave_sel(slave_sel),
        .running(running), .hc(hc), .proto_err(proto_err)
    );

    lsr_slot_decode #(.N_CH(N_CH), .HCW(HCW), .CHW(CHW)) u_dec (
        .running(running), .hc(hc), .flags(flags), .chan(vid_chan)
    );

    assign vid_valid = flags.valid;
    assign trig      = flags.trig;
    assign vid_oe    = flags.oe;
    assign eos_n     = ~flags.eos;

    // Edge outputs of the level-only synchronizers are not needed.
    logic unused_ok;
    assign unused_ok = &{1'b0, lc_lvl, ex_rise, ex_fall};
endmodule

// File: rtl/lsr_sequencer_chk.sv
module lsr_sequencer_chk #(
    parameter int N_CH = 64,
    localparam int CHW = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input logic           clk,
    input logic           rst,
    input logic           vid_valid,
    input logic [CHW-1:0] vid_chan,
    input logic           vid_oe,
    input logic           trig,
    input logic           eos_n,
    input logic           proto_err
);
    // R3
    trig_in_window_chk: assert property (@(posedge clk) disable iff (rst)
        trig |-> vid_valid);

    // R2
    valid_driven_chk: assert property (@(posedge clk) disable iff (rst)
        vid_valid |-> vid_oe);

    // R2
    chan_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        vid_valid |-> (int'(vid_chan) < N_CH));

    // R2
    chan_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (vid_valid && $past(vid_valid)) |-> $stable(vid_chan));

    // R5
    eos_hiz_chk: assert property (@(posedge clk) disable iff (rst)
        !eos_n |-> (!vid_oe && !vid_valid));

    // R4
    eos_follows_scan_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(eos_n) |-> $past(vid_oe));

    // R7
    err_single_chk: assert property (@(posedge clk) disable iff (rst)
        proto_err |=> !proto_err);
endmodule

bind lsr_sequencer lsr_sequencer_chk #(.N_CH(N_CH)) u_chk (
    .clk(clk), .rst(rst), .vid_valid(vid_valid), .vid_chan(vid_chan),
    .vid_oe(vid_oe), .trig(trig), .eos_n(eos_n), .proto_err(proto_err)
);

// File: tb/lsr_sequencer_test.sv
`timescale 1ns/1ps
module lsr_sequencer_test;
    localparam int N    = 4;
    localparam int DLY  = 8;
    localparam int SETL = 7;              // system cycles after each line edge
    localparam int LAST = 37 + 8 * (N + 1) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_clk = 1'b0;
    logic line_rst = 1'b0;
    logic ext_start_n = 1'b1;
    logic slave_sel = 1'b0;
    logic integ_win, vid_valid, vid_oe, trig, eos_n, proto_err;
    logic [1:0] vid_chan;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // bench model
    int m_state = 0;      // 0 idle, 1 armed, 2 run
    int m_hc    = 0;
    int rise_cnt = 0;
    bit hist [0:1023];
    int err_exp = 0;
    int err_seen = 0;

    always #4 clk = ~clk;

    lsr_sequencer #(.N_CH(N), .SYNC_STAGES(2), .INTEG_DLY(DLY)) uut (
        .clk(clk), .rst(rst), .line_clk(line_clk), .line_rst(line_rst),
        .ext_start_n(ext_start_n), .slave_sel(slave_sel),
        .integ_win(integ_win), .vid_valid(vid_valid), .vid_chan(vid_chan),
        .vid_oe(vid_oe), .trig(trig), .eos_n(eos_n), .proto_err(proto_err)
    );

    always @(posedge clk) if (!rst && proto_err) err_seen++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic model_step();
        if (m_hc == LAST) begin
            m_state = 0;
            m_hc = 0;
        end else begin
            m_hc++;
        end
    endtask

    task automatic check_outputs();
        int ev = 0, et = 0, eo = 0, ee = 0, ec = 0, ei;
        if (m_state == 2) begin
            if (m_hc < 37) eo = 1;
            else if ((m_hc - 37) / 8 < N) begin
                eo = 1;
                ec = (m_hc - 37) / 8;
                ev = ((m_hc - 37) % 8) < 3;
                et = ((m_hc - 37) % 8) == 2;
            end else ee = 1;
        end
        ei = (rise_cnt >= DLY) ? int'(hist[rise_cnt - DLY]) : 0;
        chk(vid_valid == ev, "R2 vid_valid", vid_valid, ev);
        if (ev) chk(vid_chan == ec, "R2 vid_chan", vid_chan, ec);
        chk(trig == et, "R3 trig", trig, et);
        chk(eos_n == !ee, "R4 eos_n", eos_n, !ee);
        chk(vid_oe == eo, "R5 R1 R9 vid_oe", vid_oe, eo);
        chk(integ_win == ei, "R6 integ_win", integ_win, ei);
    endtask

    task automatic do_rise(input logic v);
        int pre = m_state;
        logic old = line_rst;
        @(negedge clk);
        line_clk = 1'b1;
        line_rst = v;
        rise_cnt++;
        hist[rise_cnt] = v;
        if (pre == 2) begin
            if (v && !old) err_exp++;
            model_step();
        end else if (pre == 0 && !v && old) m_state = 1;
        else if (pre == 1 && v && !old) m_state = 0;
        repeat (SETL) @(negedge clk);
        check_outputs();
    endtask

    task automatic do_fall();
        int pre = m_state;
        @(negedge clk);
        line_clk = 1'b0;
        if (pre == 1 && (!slave_sel || !ext_start_n)) begin
            m_state = 2;
            m_hc = 2;
        end else if (pre == 2) model_step();
        repeat (SETL) @(negedge clk);
        check_outputs();
    endtask

    task automatic cycles(input int n, input logic v);
        for (int i = 0; i < n; i++) begin
            do_rise(v);
            do_fall();
        end
    endtask

    initial begin
        hist[0] = 1'b0;
        repeat (4) @(negedge clk);
        // R10: outputs during reset
        chk(vid_oe == 0 && vid_valid == 0 && trig == 0, "R10 video idle in reset", vid_oe, 0);
        chk(eos_n == 1 && integ_win == 0 && proto_err == 0, "R10 eos/integ in reset", eos_n, 1);
        rst = 1'b0;
        repeat (6) @(negedge clk);
        chk(vid_oe == 0 && vid_valid == 0 && trig == 0, "R10 video idle after reset", vid_oe, 0);
        chk(eos_n == 1 && integ_win == 0, "R10 eos/integ after reset", eos_n, 1);

        // R1 R2 R3 R4 R5 R6: master scan
        cycles(3, 1'b0);
        cycles(12, 1'b1);
        cycles(45, 1'b0);
        chk(err_seen == 0, "R7 no spurious error", err_seen, 0);

        // R7 R8: line reset edges during a readout
        cycles(10, 1'b1);
        cycles(10, 1'b0);
        cycles(10, 1'b1);     // rise in mid scan
        cycles(30, 1'b0);     // fall in mid scan, scan completes, no restart
        chk(err_seen == err_exp, "R7 proto_err count", err_seen, err_exp);
        chk(err_exp == 1, "R7 error stimulus applied", err_exp, 1);
        chk(m_state == 0 && vid_oe == 0, "R8 idle after ignored fall", vid_oe, 0);

        // R9: slave start from ext_start_n
        slave_sel = 1'b1;
        cycles(10, 1'b1);
        cycles(15, 1'b0);     // armed, but no start yet
        chk(vid_oe == 0, "R9 held off while ext high", vid_oe, 0);
        ext_start_n = 1'b0;
        cycles(2, 1'b0);
        ext_start_n = 1'b1;
        cycles(42, 1'b0);
        chk(err_seen == err_exp, "R7 final error count", err_seen, err_exp);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule